// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This block sits between a pulse-width controller and the two switch drivers of a synchronous buck power stage. It takes one PWM command with three levels (high, low, floating), given as a valid bit plus a level bit. From it the block derives separate enables for the high-side and low-side switches. It never turns one switch on until digital feedback shows that the opposite switch has really turned off.

On a rising command, the low-side enable drops at once. The high-side enable rises only after the low-side gate is reported low, followed by a short programmable dead phase. On a falling command, the high-side enable drops at once. The low side waits for the switch node to be reported low, then for its own dead phase. If the switch node never falls, for example while the converter sinks current, a longer fallback timer starts once the high-side gate is reported discharged. When that timer expires, the low side turns on anyway, so the bootstrap capacitor is recharged every cycle.

There are two further inputs, both active low. A stage-off input forces both switches off. A diode-mode input keeps the low-side switch off for light-load operation, while the high side still follows the command. Every asynchronous input goes through a two-stage synchronizer, so the controller reacts to an input change at the third rising clock edge after it.

Top module: `buck_gate_sequencer`

## Requirements
- R1: While reset is high, and on the first edge after it, both enables are 0 and `seq_state` is 0 (idle).
- R2: After the command goes high, `hi_gate_en` rises only once the synchronized `lo_gate_low` has been seen. It rises exactly HS_DEAD_CYC edges after the edge that moves the sequencer into its high-side dead phase (`seq_state` 2). With the default parameters and `lo_gate_low` already high, this is 8 edges after the command change.
- R3: After the command goes low, `lo_gate_en` rises only once the synchronized `sw_node_low` has been seen, and then LS_DEAD_CYC edges later. With the defaults this is 9 edges after `sw_node_low` rises.
- R4: If `sw_node_low` stays low, `lo_gate_en` rises FB_CYC edges after the synchronized `hi_gate_low` is first seen. FB_CYC is the 250 ns fallback time divided by the clock period, rounded up: 25 at a 10 ns clock, which is 27 edges after the `hi_gate_low` change.
- R5: The fallback count must exceed LS_DEAD_CYC; otherwise elaboration reports an error.
- R6: A floating command (`pwm_valid` = 0) turns both enables off 3 edges after the change and keeps them off, whatever the feedback flags do.
- R7: With `drv_off_n` = 0, both enables turn off 3 edges after the change and stay off while the PWM level toggles.
- R8: With `diode_mode_n` = 0, `lo_gate_en` never rises. A low command then leaves both enables off, and a high command still runs the high-side sequence.
- R9: A command reversal before a pending turn-on completes cancels that turn-on, and the opposite sequence begins without the cancelled enable ever rising.
- R10: `hi_gate_en` and `lo_gate_en` are never 1 in the same cycle.
- R11: `seq_state` encodes the sequencer position: 0 idle, 1 waiting for low-side gate low, 2 high-side dead phase, 3 high side on, 4 waiting for switch node low, 5 low-side dead phase, 6 low side on.
- R12: On any command change, the enable that was on drops 3 edges after the change, before any turn-on of the other switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_valid | input | 1 | 1 when the PWM command is driven, 0 when it floats |
| pwm_high | input | 1 | Level of the PWM command when valid |
| drv_off_n | input | 1 | Active-low forced off for both switches |
| diode_mode_n | input | 1 | Active-low: keep the low-side switch off |
| lo_gate_low | input | 1 | Comparator flag: low-side gate is below threshold |
| sw_node_low | input | 1 | Comparator flag: switch node is below threshold |
| hi_gate_low | input | 1 | Comparator flag: high-side gate-source is discharged |
| hi_gate_en | output | 1 | High-side switch enable |
| lo_gate_en | output | 1 | Low-side switch enable |
| seq_state | output | 3 | Sequencer state code (see R11) |

## Verification
The hardest path to reach is the fallback turn-on. It needs a falling command while the switch-node flag never comes, and the high-side discharge flag must arrive late enough that the expected edge is not also explained by the normal dead phase. The stimulus holds `sw_node_low` low through the whole low-side wait and raises `hi_gate_low` a few cycles into it. The bench then expects the low-side enable at exactly the fallback count, well after the point where the normal dead phase would have ended. The cancellation cases are also hard to reach, because each needs the command to reverse inside a wait window that is only a few cycles long. They are reached by withholding the feedback flag for the pending side and reversing the command five cycles after the first change.

// File: rtl/bgs_pkg.sv
package bgs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WAIT_LO  = 3'd1,
    ST_HI_DEAD  = 3'd2,
    ST_HI_ON    = 3'd3,
    ST_WAIT_SW  = 3'd4,
    ST_LO_DEAD  = 3'd5,
    ST_LO_ON    = 3'd6
  } seq_state_t;

  typedef enum logic [1:0] {
    TGT_OFF = 2'd0,
    TGT_HI  = 2'd1,
    TGT_LO  = 2'd2
  } target_t;

endpackage

// File: rtl/bgs_sync.sv
module bgs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/bgs_timer.sv
module bgs_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic done,
  output logic busy
);

  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (run)    cnt <= cnt + W'(1);
  end

  assign done = run && (cnt == W'(LIMIT - 1));
  assign busy = (cnt != '0);

endmodule

// File: rtl/buck_gate_sequencer.sv
module buck_gate_sequencer
  import bgs_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 10000,
  parameter int FALLBACK_NS   = 250,
  parameter int HS_DEAD_CYC   = 4,
  parameter int LS_DEAD_CYC   = 6,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwm_valid,
  input  logic       pwm_high,
  input  logic       drv_off_n,
  input  logic       diode_mode_n,
  input  logic       lo_gate_low,
  input  logic       sw_node_low,
  input  logic       hi_gate_low,
  output logic       hi_gate_en,
  output logic       lo_gate_en,
  output logic [2:0] seq_state
);

  localparam int FB_CYC = (FALLBACK_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int N_IN   = 7;

  // R5: fallback must outlast the normal low-side dead phase
  if (FB_CYC <= LS_DEAD_CYC) begin : g_fb_too_short
    $error("fallback count must exceed LS_DEAD_CYC");
  end

  logic valid_s, high_s, dis_s, skip_s, lsg_s, sw_s, hsg_s;
  logic [N_IN-1:0] raw_in, syn_in;

  assign raw_in = {pwm_valid, pwm_high, drv_off_n, diode_mode_n,
                   lo_gate_low, sw_node_low, hi_gate_low};

  bgs_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (syn_in)
  );

  assign {valid_s, high_s, dis_s, skip_s, lsg_s, sw_s, hsg_s} = syn_in;

  seq_state_t state, nxt;
  target_t    tgt;

  always_comb begin
    if (!dis_s || !valid_s) tgt = TGT_OFF;
    else if (high_s)        tgt = TGT_HI;
    else if (skip_s)        tgt = TGT_LO;
    else                    tgt = TGT_OFF;
  end

  logic hs_done, hs_busy, ls_done, ls_busy, fb_done, fb_busy;
  logic fb_zone;

  assign fb_zone = (state == ST_WAIT_SW) || (state == ST_LO_DEAD);

  bgs_timer #(.LIMIT(HS_DEAD_CYC)) u_hs_dead (
    .clk (clk), .rst (rst),
    .clr (state != ST_HI_DEAD),
    .run (state == ST_HI_DEAD),
    .done(hs_done), .busy(hs_busy)
  );

  bgs_timer #(.LIMIT(LS_DEAD_CYC)) u_ls_dead (
    .clk (clk), .rst (rst),
    .clr (state != ST_LO_DEAD),
    .run (state == ST_LO_DEAD),
    .done(ls_done), .busy(ls_busy)
  );

  bgs_timer #(.LIMIT(FB_CYC)) u_fallback (
    .clk (clk), .rst (rst),
    .clr (!fb_zone),
    .run (fb_zone && (hsg_s || fb_busy)),
    .done(fb_done), .busy(fb_busy)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (tgt == TGT_HI)      nxt = ST_WAIT_LO;
        else if (tgt == TGT_LO) nxt = ST_WAIT_SW;
      end
      ST_WAIT_LO: begin
        if (tgt == TGT_LO)      nxt = ST_WAIT_SW;
        else if (lsg_s)         nxt = ST_HI_DEAD;
      end
      ST_HI_DEAD: begin
        if (tgt == TGT_LO)      nxt = ST_WAIT_SW;
        else if (hs_done)       nxt = ST_HI_ON;
      end
      ST_HI_ON: begin
        if (tgt == TGT_LO)      nxt = ST_WAIT_SW;
      end
      ST_WAIT_SW: begin
        if (tgt == TGT_HI)      nxt = ST_WAIT_LO;
        else if (fb_done)       nxt = ST_LO_ON;
        else if (sw_s)          nxt = ST_LO_DEAD;
      end
      ST_LO_DEAD: begin
        if (tgt == TGT_HI)           nxt = ST_WAIT_LO;
        else if (ls_done || fb_done) nxt = ST_LO_ON;
      end
      ST_LO_ON: begin
        if (tgt == TGT_HI)      nxt = ST_WAIT_LO;
      end
      default:                  nxt = ST_IDLE;
    endcase
    if (tgt == TGT_OFF) nxt = ST_IDLE;
  end

  logic hs_q, ls_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      hs_q  <= 1'b0;
      ls_q  <= 1'b0;
    end else begin
      state <= nxt;
      hs_q  <= (nxt == ST_HI_ON);
      ls_q  <= (nxt == ST_LO_ON);
    end
  end

  assign hi_gate_en = hs_q;
  assign lo_gate_en = ls_q;
  assign seq_state  = state;

endmodule

// File: rtl/bgs_checker.sv
module bgs_checker
  import bgs_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       hi_gate_en,
  input logic       lo_gate_en,
  input logic [2:0] seq_state,
  input logic       dis_s,
  input logic       skip_s
);

  AST_NO_CROSS_CONDUCTION: assert property (@(posedge clk) disable iff (rst)
    !(hi_gate_en && lo_gate_en)); // R10

  AST_HI_AFTER_DEAD: assert property (@(posedge clk) disable iff (rst)
    $rose(hi_gate_en) |-> ($past(seq_state) == ST_HI_DEAD)); // R2

  AST_LO_AFTER_WAIT: assert property (@(posedge clk) disable iff (rst)
    $rose(lo_gate_en) |-> ($past(seq_state) == ST_LO_DEAD ||
                           $past(seq_state) == ST_WAIT_SW)); // R3

  AST_OFF_FORCES_LOW: assert property (@(posedge clk) disable iff (rst)
    !dis_s |=> (!hi_gate_en && !lo_gate_en)); // R7

  AST_DIODE_MODE_NO_LO: assert property (@(posedge clk) disable iff (rst)
    !skip_s |=> !lo_gate_en); // R8

  AST_STATE_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    seq_state != 3'd7); // R11

endmodule

bind buck_gate_sequencer bgs_checker u_bgs_checker (
  .clk        (clk),
  .rst        (rst),
  .hi_gate_en (hi_gate_en),
  .lo_gate_en (lo_gate_en),
  .seq_state  (seq_state),
  .dis_s      (dis_s),
  .skip_s     (skip_s)
);

// File: tb/test_buck_gate_sequencer.sv
module test_buck_gate_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwm_valid = 1'b0, pwm_high = 1'b0, drv_off_n = 1'b1, diode_mode_n = 1'b1;
  logic lo_gate_low = 1'b1, sw_node_low = 1'b0, hi_gate_low = 1'b0;
  logic hi_gate_en, lo_gate_en;
  logic [2:0] seq_state;

  always #(CLK_PERIOD/2) clk = ~clk;

  buck_gate_sequencer i_buck_gate_sequencer (
    .clk          (clk),
    .rst          (rst),
    .pwm_valid    (pwm_valid),
    .pwm_high     (pwm_high),
    .drv_off_n    (drv_off_n),
    .diode_mode_n (diode_mode_n),
    .lo_gate_low  (lo_gate_low),
    .sw_node_low  (sw_node_low),
    .hi_gate_low  (hi_gate_low),
    .hi_gate_en   (hi_gate_en),
    .lo_gate_en   (lo_gate_en),
    .seq_state    (seq_state)
  );

  int unsigned cyc = 0;
  int errors = 0;
  int checks = 0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int unsigned at;
    logic        hs;
    logic        ls;
    string       tag;
  } ev_t;

  ev_t sb[$];

  task automatic push_ev(int unsigned d, logic hs, logic ls, string tag);
    ev_t e;
    e.at = cyc + d; e.hs = hs; e.ls = ls; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected output changes and compares cycle and value
  logic [1:0] last_out = 2'b00;
  always @(negedge clk) begin
    if (!rst) begin
      if (hi_gate_en && lo_gate_en) begin
        checks++; errors++;
        $display("FAIL R10: actual=both_on expected=not_both at cycle %0d", cyc);
      end
      if ({hi_gate_en, lo_gate_en} != last_out) begin
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL unexpected change: actual=%b expected=%b at cycle %0d",
                   {hi_gate_en, lo_gate_en}, last_out, cyc);
        end else begin
          ev_t e;
          e = sb.pop_front();
          if (e.at != cyc || e.hs != hi_gate_en || e.ls != lo_gate_en) begin
            errors++;
            $display("FAIL %s: actual=%b@%0d expected=%b@%0d", e.tag,
                     {hi_gate_en, lo_gate_en}, cyc, {e.hs, e.ls}, e.at);
          end
        end
      end
      last_out <= {hi_gate_en, lo_gate_en};
    end
  end

  task automatic finish_run();
    check("all expected events seen", sb.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    settle(4);
    check("R1 hs in reset", hi_gate_en, 0);
    check("R1 ls in reset", lo_gate_en, 0);
    check("R1 state in reset", seq_state, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 state after reset", seq_state, 0);
    settle(4);

    // R2: rising command with low-side gate already low
    push_ev(8, 1, 0, "R2");
    pwm_valid = 1'b1; pwm_high = 1'b1;
    settle(14);
    check("R11 hs on code", seq_state, 3);

    // R12 then R3: falling command, switch node arrives late
    push_ev(3, 0, 0, "R12");
    push_ev(14, 0, 1, "R3");
    pwm_high = 1'b0;
    settle(5);
    sw_node_low = 1'b1;
    settle(14);
    check("R11 ls on code", seq_state, 6);

    // R2 with late low-side-gate flag
    push_ev(3, 0, 0, "R12");
    push_ev(13, 1, 0, "R2");
    sw_node_low = 1'b0; lo_gate_low = 1'b0; pwm_high = 1'b1;
    settle(6);
    lo_gate_low = 1'b1;
    settle(12);

    // R4: fallback with switch node never low
    push_ev(3, 0, 0, "R12");
    push_ev(31, 0, 1, "R4");
    pwm_high = 1'b0;
    settle(4);
    hi_gate_low = 1'b1;
    settle(35);

    // R9: pending high-side turn-on cancelled
    push_ev(3, 0, 0, "R12");
    push_ev(15, 0, 1, "R9");
    hi_gate_low = 1'b0; lo_gate_low = 1'b0; pwm_high = 1'b1;
    settle(5);
    pwm_high = 1'b0; sw_node_low = 1'b1;
    settle(16);

    // back to high side
    push_ev(3, 0, 0, "R12");
    push_ev(8, 1, 0, "R2");
    lo_gate_low = 1'b1; sw_node_low = 1'b0; pwm_high = 1'b1;
    settle(12);

    // R9: pending low-side turn-on cancelled
    push_ev(3, 0, 0, "R12");
    push_ev(13, 1, 0, "R9");
    pwm_high = 1'b0;
    settle(5);
    pwm_high = 1'b1;
    settle(12);

    // R8: diode mode keeps low side off
    push_ev(3, 0, 0, "R8");
    sw_node_low = 1'b1; hi_gate_low = 1'b1;
    diode_mode_n = 1'b0; pwm_high = 1'b0;
    settle(40);
    check("R8 ls held off", lo_gate_en, 0);
    check("R8 idle state", seq_state, 0);
    push_ev(8, 1, 0, "R8");
    pwm_high = 1'b1;
    settle(12);
    push_ev(3, 0, 0, "R8");
    pwm_high = 1'b0;
    settle(40);
    check("R8 ls still off", lo_gate_en, 0);
    push_ev(10, 0, 1, "R8");
    hi_gate_low = 1'b0; diode_mode_n = 1'b1;
    settle(14);

    // R6: floating command
    push_ev(3, 0, 0, "R6");
    pwm_valid = 1'b0; hi_gate_low = 1'b1;
    settle(30);
    check("R6 hs off", hi_gate_en, 0);
    check("R6 state idle", seq_state, 0);
    push_ev(8, 1, 0, "R6");
    hi_gate_low = 1'b0; pwm_valid = 1'b1; pwm_high = 1'b1;
    settle(12);

    // R7: forced off ignores PWM toggles
    push_ev(3, 0, 0, "R7");
    drv_off_n = 1'b0;
    settle(10);
    for (int i = 0; i < 4; i++) begin
      pwm_high = ~pwm_high;
      settle(10);
    end
    check("R7 hs off", hi_gate_en, 0);
    check("R7 ls off", lo_gate_en, 0);
    check("R7 state idle", seq_state, 0);
    push_ev(8, 1, 0, "R7");
    drv_off_n = 1'b1; pwm_high = 1'b1;
    settle(12);

    finish_run();
  end

endmodule